// File: doc/BRIEF.md
# Regional Foldback Sum-Term Expander

A group of sixteen macrocells shares a regional foldback bus. Each macrocell has five local product terms. It inverts one of them, picked by a small select field, and places the result on the bus as its single foldback term. Every macrocell in the region sees all sixteen foldback terms.

Each macrocell forms its sum term as the OR of its own five product terms and whichever foldback terms its 16-bit use mask enables. A sum term can therefore reach 21 product-term inputs with only one extra OR level. The block is purely combinational. The AND array that produces the product terms, and the register stage after the sum, sit outside this block.

Top module: `fb_region_expander`

## Requirements
- R1: For a macrocell whose foldback select `s` is 0 to 4, its bit on `fb_bus_o` equals the inverse of its local product term `s` (product term k of macrocell m is `pt_i[m*5+k]`, and its select is `fb_sel_i[m*3 +: 3]`).
- R2: A foldback select of 5, 6 or 7 drives that macrocell's foldback bit to 0.
- R3: When a macrocell's use mask (`fb_mask_i[m*16 +: 16]`) is all zero, its `sum_o` bit is the OR of its five local product terms only.
- R4: Mask bit j of macrocell m ORs foldback term j (bus bit j) into `sum_o[m]`. Clear mask bits have no effect on the sum.
- R5: Any macrocell may use the foldback term of any macrocell in the region, including its own.
- R6: A single true input among the 21 possible inputs (5 local terms plus 16 masked foldback terms) is enough to raise the sum.
- R7: `sum_o[m]` is 0 when all local terms are 0 and every enabled foldback term is 0.
- R8: The outputs follow the inputs combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pt_i | input | 80 | Local product terms, 5 per macrocell, macrocell m at bits m*5 +: 5 |
| fb_sel_i | input | 48 | Foldback source select, 3 bits per macrocell |
| fb_mask_i | input | 256 | Foldback use mask, 16 bits per macrocell |
| fb_bus_o | output | 16 | Regional foldback bus, bit m from macrocell m |
| sum_o | output | 16 | Sum term per macrocell |

## Verification
The select test steps every macrocell through all eight select codes against a mixed product-term pattern. This separates correct inversion from a plain pass-through, and separates a dead code from a wrapped index. The mask tests give each macrocell one enabled foldback term at a rotating offset, with every other bus bit held low. This shows whether each mask bit reaches the right bus bit and not a neighbour. Single-input tests light exactly one of the 21 inputs, and an all-false case confirms the sum can drop. A random sweep then mixes local and foldback contributions together.

// File: rtl/fb_pkg.sv
package fb_pkg;
  parameter int unsigned N_MC  = 16;
  parameter int unsigned N_PT  = 5;
  parameter int unsigned SEL_W = $clog2(N_PT);
  localparam int unsigned PT_W   = N_MC * N_PT;
  localparam int unsigned SELV_W = N_MC * SEL_W;
  localparam int unsigned MASK_W = N_MC * N_MC;
endpackage

// File: rtl/fb_src_sel.sv
module fb_src_sel #(
  parameter int unsigned N_PT  = 5,
  parameter int unsigned SEL_W = 3
) (
  input  logic [N_PT-1:0]  pt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fb_o
);
  logic [N_PT-1:0] sel_oh;

  // out-of-range codes decode to no term -> foldback low
  always_comb begin
    sel_oh = '0;
    for (int k = 0; k < int'(N_PT); k++)
      sel_oh[k] = (sel_i == SEL_W'(k));
  end

  assign fb_o = |(sel_oh & ~pt_i);
endmodule

// File: rtl/fb_sum_or.sv
module fb_sum_or #(
  parameter int unsigned N_PT = 5,
  parameter int unsigned N_MC = 16
) (
  input  logic [N_PT-1:0] pt_i,
  input  logic [N_MC-1:0] fb_bus_i,
  input  logic [N_MC-1:0] mask_i,
  output logic            sum_o
);
  logic local_any;
  logic fold_any;

  assign local_any = |pt_i;
  assign fold_any  = |(fb_bus_i & mask_i);
  assign sum_o     = local_any | fold_any;
endmodule

// File: rtl/fb_region_expander.sv
module fb_region_expander
  import fb_pkg::*;
(
  input  logic [PT_W-1:0]   pt_i,
  input  logic [SELV_W-1:0] fb_sel_i,
  input  logic [MASK_W-1:0] fb_mask_i,
  output logic [N_MC-1:0]   fb_bus_o,
  output logic [N_MC-1:0]   sum_o
);
  logic [N_MC-1:0] fb_bus;

  for (genvar m = 0; m < int'(N_MC); m++) begin : g_mc
    logic [N_PT-1:0]  pt_mc;
    logic [SEL_W-1:0] sel_mc;
    logic [N_MC-1:0]  mask_mc;

    assign pt_mc   = pt_i[m*N_PT +: N_PT];
    assign sel_mc  = fb_sel_i[m*SEL_W +: SEL_W];
    assign mask_mc = fb_mask_i[m*N_MC +: N_MC];

    fb_src_sel #(.N_PT(N_PT), .SEL_W(SEL_W)) u_src (
      .pt_i (pt_mc),
      .sel_i(sel_mc),
      .fb_o (fb_bus[m])
    );

    fb_sum_or #(.N_PT(N_PT), .N_MC(N_MC)) u_sum (
      .pt_i    (pt_mc),
      .fb_bus_i(fb_bus),
      .mask_i  (mask_mc),
      .sum_o   (sum_o[m])
    );

    always_comb begin
      if (int'(sel_mc) < int'(N_PT))
        AST_FB_INVERTS: assert (fb_bus[m] != pt_mc[sel_mc]); // R1
      else
        AST_FB_DEAD_CODE: assert (!fb_bus[m]); // R2
      if (|pt_mc)
        AST_SUM_HAS_LOCAL: assert (sum_o[m]); // R3
      if (|(fb_bus & mask_mc))
        AST_SUM_HAS_FOLD: assert (sum_o[m]); // R4
      if (!sum_o[m])
        AST_SUM_LOW_CLEAN: assert (!(|pt_mc) && !(|(fb_bus & mask_mc))); // R7
    end
  end

  assign fb_bus_o = fb_bus;
endmodule

// File: tb/fb_region_expander_tb.sv
module fb_region_expander_tb_top;
  import fb_pkg::*;

  logic clk;
  logic rst_ni;
  logic [PT_W-1:0]   pt;
  logic [SELV_W-1:0] sel;
  logic [MASK_W-1:0] mask;
  logic [N_MC-1:0]   fb_bus;
  logic [N_MC-1:0]   sum;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  fb_region_expander dut_i (
    .pt_i     (pt),
    .fb_sel_i (sel),
    .fb_mask_i(mask),
    .fb_bus_o (fb_bus),
    .sum_o    (sum)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [N_MC-1:0] exp_fb(input logic [PT_W-1:0] p, input logic [SELV_W-1:0] s);
    logic [N_MC-1:0] r;
    for (int m = 0; m < int'(N_MC); m++) begin
      int c = int'(s[m*SEL_W +: SEL_W]);
      r[m] = (c < int'(N_PT)) ? ~p[m*N_PT + c] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [N_MC-1:0] exp_sum(input logic [PT_W-1:0] p, input logic [SELV_W-1:0] s,
                                               input logic [MASK_W-1:0] k);
    logic [N_MC-1:0] f = exp_fb(p, s);
    logic [N_MC-1:0] r;
    for (int m = 0; m < int'(N_MC); m++) begin
      logic acc = 1'b0;
      for (int t = 0; t < int'(N_PT); t++) acc |= p[m*N_PT + t];
      for (int j = 0; j < int'(N_MC); j++) acc |= f[j] & k[m*N_MC + j];
      r[m] = acc;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [N_MC-1:0] act, input logic [N_MC-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [PT_W-1:0] p, input logic [SELV_W-1:0] s, input logic [MASK_W-1:0] k);
    @(posedge clk);
    pt = p; sel = s; mask = k;
    @(negedge clk);
  endtask

  task automatic t_reset;
    apply('0, '0, '0);
    check("R3 reset sum", sum, '0);
    check("R1 reset bus", fb_bus, '1);
  endtask

  task automatic t_fb_select;
    logic [PT_W-1:0] p;
    for (int i = 0; i < int'(PT_W); i++) p[i] = ((i * 7) % 3) == 1;
    for (int c = 0; c < 8; c++) begin
      logic [SELV_W-1:0] s;
      for (int m = 0; m < int'(N_MC); m++) s[m*SEL_W +: SEL_W] = SEL_W'((c + m) % 8);
      apply(p, s, '0);
      check((c < 5) ? "R1 select" : "R2 select", fb_bus, exp_fb(p, s));
    end
  endtask

  task automatic t_dead_codes;
    logic [SELV_W-1:0] s;
    for (int c = 5; c < 8; c++) begin
      for (int m = 0; m < int'(N_MC); m++) s[m*SEL_W +: SEL_W] = SEL_W'(c);
      apply('0, s, '1);
      check("R2 dead code bus", fb_bus, '0);
      check("R7 dead code sum", sum, '0);
    end
  endtask

  task automatic t_local_only;
    for (int t = 0; t < int'(N_PT); t++) begin
      logic [PT_W-1:0] p = '0;
      logic [N_MC-1:0] e = '0;
      for (int m = 0; m < int'(N_MC); m += 3) begin
        p[m*N_PT + t] = 1'b1;
        e[m] = 1'b1;
      end
      apply(p, '1, '0);
      check("R3 local only", sum, e);
    end
    apply('0, '0, '0);
    check("R3 zero mask ignores bus", sum, '0);
  endtask

  task automatic t_mask_route;
    for (int j = 0; j < int'(N_MC); j += 5) begin
      for (int sh = 0; sh < int'(N_MC); sh += 4) begin
        logic [SELV_W-1:0] s = '1;
        logic [MASK_W-1:0] k = '0;
        logic [N_MC-1:0]   e = '0;
        s[j*SEL_W +: SEL_W] = '0;
        for (int m = 0; m < int'(N_MC); m++) begin
          int b = (m + sh) % int'(N_MC);
          k[m*N_MC + b] = 1'b1;
          e[m] = (b == j);
        end
        apply('0, s, k);
        check("R4 mask route", sum, e);
        check("R5 own and others", sum[j], ((j + sh) % int'(N_MC)) == j);
      end
    end
  endtask

  task automatic t_single_input;
    int m = 3;
    for (int i = 0; i < int'(N_PT + N_MC); i++) begin
      logic [PT_W-1:0]   p = '0;
      logic [SELV_W-1:0] s = '1;
      logic [MASK_W-1:0] k = '0;
      logic [N_MC-1:0]   e = '0;
      if (i < int'(N_PT)) begin
        p[m*N_PT + i] = 1'b1;
      end else begin
        int j = i - int'(N_PT);
        s[j*SEL_W +: SEL_W] = 3'd2;
        k[m*N_MC + j] = 1'b1;
        for (int q = 0; q < int'(N_MC); q++) k[q*N_MC + ((j + 1) % int'(N_MC))] = 1'b1;
      end
      e[m] = 1'b1;
      apply(p, s, k);
      check("R6 one of 21", sum, e);
    end
  endtask

  task automatic t_all_false;
    apply('0, '1, '1);
    check("R7 all false", sum, '0);
  endtask

  task automatic t_comb;
    logic [PT_W-1:0] p = '0;
    apply('0, '1, '0);
    #1;
    p[7*N_PT + 4] = 1'b1;
    pt = p;
    #1;
    check("R8 no clock", sum, 16'h0080);
  endtask

  task automatic t_sweep;
    for (int v = 0; v < 200; v++) begin
      logic [PT_W-1:0]   p;
      logic [SELV_W-1:0] s;
      logic [MASK_W-1:0] k;
      for (int i = 0; i < int'(PT_W); i++) p[i] = ($urandom % 8) == 0;
      for (int i = 0; i < int'(SELV_W); i++) s[i] = $urandom % 2;
      for (int i = 0; i < int'(MASK_W); i++) k[i] = ($urandom % 6) == 0;
      apply(p, s, k);
      check("R4 sweep sum", sum, exp_sum(p, s, k));
      check("R1 sweep bus", fb_bus, exp_fb(p, s));
    end
  endtask

  initial begin
    pt = '0; sel = '0; mask = '0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_fb_select();
    t_dead_codes();
    t_local_only();
    t_mask_route();
    t_single_input();
    t_all_false();
    t_comb();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule